// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flag Update

This block is the arithmetic and logic unit of a small eight-bit processor datapath. It is purely combinational: an operation code selects one of seventeen functions, applied to a left operand, a right operand, the incoming carry flag and the incoming zero flag. The outputs are the result, a vector of new flag values and a write mask that marks which flags this operation updates. Flags outside the mask keep their old values in the status register, which lies outside this block.

One shared adder/subtractor serves addition, subtraction, two's complement, increment and decrement. A second unit handles the bitwise functions, shifts, rotates and the nibble swap. A third unit forms the flags and the mask from the operation class. The signed flag always equals negative XOR overflow, so signed comparisons can be taken straight from it.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, COM=7, NEG=8, INC=9, DEC=10, LSL=11, LSR=12, ROL=13, ROR=14, ASR=15, SWAP=16. Codes 17 to 31 return `a_i` unchanged and an all-zero write mask.
- R2: Flag and mask bits use the layout bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S, bit5 H. Only flags whose mask bit is 1 are meaningful. N is the result MSB, S = N xor V, and S is written exactly when N is written.
- R3: ADD gives a+b and ADC gives a+b+c_i. C is the carry out of bit 7, H is the carry out of bit 3, V is set on signed overflow, and Z is set when the result is 0. All six flags are written.
- R4: SUB gives a-b and SBC gives a-b-c_i. C is the borrow out of bit 7, H is the borrow out of the low nibble, and V is set on signed overflow. All six flags are written.
- R5: For SBC, Z is 1 only if the result is 0 and z_i is 1. For every other operation that writes Z, Z is 1 exactly when the result is 0.
- R6: AND, OR and XOR give the bitwise result with V=0. They write only Z, N, V and S.
- R7: COM gives 0xFF-a with C=1 and V=0. It writes Z, C, N, V and S.
- R8: NEG gives 0x00-a. C=1 unless the result is 0, V=1 only for result 0x80, and H is the borrow from the low nibble. All six flags are written.
- R9: INC gives a+1 and DEC gives a-1. V is set only for 0x7F to 0x80 (INC) and 0x80 to 0x7F (DEC). They write only Z, N, V and S, so C and H are preserved.
- R10: LSL shifts left with a 0 into bit 0 and bit 7 into C. LSR shifts right with a 0 into bit 7 and bit 0 into C.
- R11: ROL puts c_i into bit 0 and bit 7 into C. ROR puts c_i into bit 7 and bit 0 into C.
- R12: ASR keeps bit 7, shifts bits 7:1 down and puts bit 0 into C.
- R13: For LSL, LSR, ROL, ROR and ASR, V = N xor C after the operation. These operations write Z, C, N, V and S, but not H.
- R14: SWAP exchanges bits 7:4 with bits 3:0 and writes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | WIDTH | Left operand (destination register value) |
| b_i | input | WIDTH | Right operand (source register or constant) |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| res_o | output | WIDTH | Operation result |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| flag_we_o | output | 6 | Per-flag write mask, same layout |

## Verification
The bench builds the block with its default WIDTH of 8. At that width the half-carry boundary sits between bits 3 and 4, and the overflow corners are 0x7F and 0x80, so both can be hit directly. Every operation code, including the unused ones, is swept over all 256 values of the left operand with random right operand, carry and zero. This covers every carry, borrow, half-carry and overflow boundary of the unary operations exhaustively. Directed cases add the sticky-zero behaviour of SBC and the rotate-through-carry edges.

// File: rtl/alu8_pkg.sv
// Package: operation codes and flag bit positions shared by the ALU units.
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16
    } alu_op_e;

    localparam int FLAG_W = 6;
    localparam int FL_C   = 0;
    localparam int FL_Z   = 1;
    localparam int FL_N   = 2;
    localparam int FL_V   = 3;
    localparam int FL_S   = 4;
    localparam int FL_H   = 5;

    // Operations whose result comes from the shared adder/subtractor.
    function automatic logic uses_adder(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_NEG) || (op == OP_INC) ||
               (op == OP_DEC);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
// Shared adder/subtractor.
// Computes lhs + rhs + cin or lhs - rhs - cin. It reports the carry or borrow
// out of the top bit, the carry or borrow out of the low half, and signed
// overflow. Assumes WIDTH is even and at least 2.
module alu8_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             hout_o,
    output logic             vout_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] full_w;
    logic [HALF:0]  low_w;

    // Widened sums: the extra top bit is the carry, or the borrow after wrap.
    always_comb begin
        if (sub_i) begin
            full_w = {1'b0, lhs_i} - {1'b0, rhs_i} - {{WIDTH{1'b0}}, cin_i};
            low_w  = {1'b0, lhs_i[HALF-1:0]} - {1'b0, rhs_i[HALF-1:0]}
                   - {{HALF{1'b0}}, cin_i};
        end else begin
            full_w = {1'b0, lhs_i} + {1'b0, rhs_i} + {{WIDTH{1'b0}}, cin_i};
            low_w  = {1'b0, lhs_i[HALF-1:0]} + {1'b0, rhs_i[HALF-1:0]}
                   + {{HALF{1'b0}}, cin_i};
        end
    end

    // Signed overflow from operand and result sign bits.
    always_comb begin
        if (sub_i)
            vout_o = (lhs_i[WIDTH-1] != rhs_i[WIDTH-1]) &&
                     (full_w[WIDTH-1] != lhs_i[WIDTH-1]);
        else
            vout_o = (lhs_i[WIDTH-1] == rhs_i[WIDTH-1]) &&
                     (full_w[WIDTH-1] != lhs_i[WIDTH-1]);
    end

    assign sum_o  = full_w[WIDTH-1:0];
    assign cout_o = full_w[WIDTH];
    assign hout_o = low_w[HALF];

endmodule

// File: rtl/alu8_shift_logic.sv
// Bitwise, shift, rotate and half-swap unit.
// Produces the result of every operation that does not use the adder, and the
// bit that goes to carry. Unused codes pass the left operand through.
// Assumes WIDTH is even and at least 2.
module alu8_shift_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] swapped_w;

    // Half swap built bit by bit.
    for (genvar i = 0; i < HALF; i++) begin : g_swap
        assign swapped_w[i]        = a_i[i + HALF];
        assign swapped_w[i + HALF] = a_i[i];
    end

    // Result and outgoing carry selected by operation.
    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM: begin
                res_o  = ~a_i;
                cout_o = 1'b1;
            end
            OP_LSL: begin
                res_o  = {a_i[WIDTH-2:0], 1'b0};
                cout_o = a_i[WIDTH-1];
            end
            OP_LSR: begin
                res_o  = {1'b0, a_i[WIDTH-1:1]};
                cout_o = a_i[0];
            end
            OP_ROL: begin
                res_o  = {a_i[WIDTH-2:0], cin_i};
                cout_o = a_i[WIDTH-1];
            end
            OP_ROR: begin
                res_o  = {cin_i, a_i[WIDTH-1:1]};
                cout_o = a_i[0];
            end
            OP_ASR: begin
                res_o  = {a_i[WIDTH-1], a_i[WIDTH-1:1]};
                cout_o = a_i[0];
            end
            OP_SWAP: res_o = swapped_w;
            default: res_o = a_i;
        endcase
    end

    // Guard: arithmetic shift must keep the sign bit.
    always_comb begin
        if (op_i == OP_ASR)
            AST_ASR_KEEPS_SIGN: assert (res_o[WIDTH-1] == a_i[WIDTH-1]); // R12
    end

endmodule

// File: rtl/alu8_flags.sv
// Flag former.
// Builds the new flag values and the per-flag write mask from the operation
// class, the final result and the carry information of both units. Assumes
// the result is already selected; S is always N xor V.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e           op_i,
    input  logic [WIDTH-1:0]  res_i,
    input  logic              add_c_i,
    input  logic              add_h_i,
    input  logic              add_v_i,
    input  logic              sl_c_i,
    input  logic              z_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] we_o
);
    logic n_w, z_w, c_w, v_w;

    // Zero: sticky for subtract-with-carry, plain for everything else.
    always_comb begin
        z_w = (res_i == '0);
        if (op_i == OP_SBC)
            z_w = z_w & z_i;
    end

    assign n_w = res_i[WIDTH-1];

    // Carry and overflow source selected by operation class.
    always_comb begin
        c_w = sl_c_i;
        v_w = 1'b0;
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                c_w = add_c_i;
                v_w = add_v_i;
            end
            OP_INC, OP_DEC: v_w = add_v_i;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: v_w = n_w ^ sl_c_i;
            default: v_w = 1'b0;
        endcase
    end

    // Write mask per operation class.
    always_comb begin
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
                we_o = 6'b11_1111;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
                we_o = 6'b01_1110;
            OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:
                we_o = 6'b01_1111;
            default:
                we_o = 6'b00_0000;
        endcase
    end

    // Pack the flag vector.
    always_comb begin
        flags_o        = '0;
        flags_o[FL_C]  = c_w;
        flags_o[FL_Z]  = z_w;
        flags_o[FL_N]  = n_w;
        flags_o[FL_V]  = v_w;
        flags_o[FL_S]  = n_w ^ v_w;
        flags_o[FL_H]  = add_h_i;
    end

    // Guards on the zero input path and on the mask pairing of N and S.
    always_comb begin
        if (op_i == OP_SBC && !z_i)
            AST_SBC_Z_STICKY: assert (!flags_o[FL_Z]); // R5
        AST_S_PAIRS_N: assert (we_o[FL_S] == we_o[FL_N]); // R2
    end

endmodule

// File: rtl/alu8_core.sv
// Eight-bit ALU top.
// Steers operands into the shared adder/subtractor, runs the bitwise/shift
// unit in parallel, selects the result and hands it to the flag former.
// Purely combinational; the status register lies outside this block.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [4:0]        op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic [WIDTH-1:0]  res_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] flag_we_o
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    alu_op_e          op_w;
    logic [WIDTH-1:0] lhs_w, rhs_w, sum_w, sl_res_w;
    logic             cin_w, sub_w, add_c_w, add_h_w, add_v_w, sl_c_w;

    assign op_w = alu_op_e'(op_i);

    // Operand steering for the shared adder/subtractor.
    always_comb begin
        lhs_w = a_i;
        rhs_w = b_i;
        cin_w = 1'b0;
        sub_w = 1'b0;
        unique case (op_w)
            OP_ADC: cin_w = c_i;
            OP_SUB: sub_w = 1'b1;
            OP_SBC: begin
                sub_w = 1'b1;
                cin_w = c_i;
            end
            OP_NEG: begin
                lhs_w = '0;
                rhs_w = a_i;
                sub_w = 1'b1;
            end
            OP_INC: rhs_w = ONE;
            OP_DEC: begin
                rhs_w = ONE;
                sub_w = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_arith #(.WIDTH(WIDTH)) arith_i (
        .lhs_i  (lhs_w),
        .rhs_i  (rhs_w),
        .cin_i  (cin_w),
        .sub_i  (sub_w),
        .sum_o  (sum_w),
        .cout_o (add_c_w),
        .hout_o (add_h_w),
        .vout_o (add_v_w)
    );

    alu8_shift_logic #(.WIDTH(WIDTH)) shl_i (
        .op_i   (op_w),
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (c_i),
        .res_o  (sl_res_w),
        .cout_o (sl_c_w)
    );

    // Final result selection.
    assign res_o = uses_adder(op_w) ? sum_w : sl_res_w;

    alu8_flags #(.WIDTH(WIDTH)) flags_i (
        .op_i    (op_w),
        .res_i   (res_o),
        .add_c_i (add_c_w),
        .add_h_i (add_h_w),
        .add_v_i (add_v_w),
        .sl_c_i  (sl_c_w),
        .z_i     (z_i),
        .flags_o (flags_o),
        .we_o    (flag_we_o)
    );

    // Guards relating ports across the units.
    always_comb begin
        if (op_w == OP_SWAP)
            AST_SWAP_NO_FLAGS: assert (flag_we_o == '0); // R14
        if (op_w == OP_INC || op_w == OP_DEC)
            AST_INCDEC_KEEP_C: assert (!flag_we_o[FL_C] && !flag_we_o[FL_H]); // R9
        if (op_w == OP_ROL)
            AST_ROL_CARRY_IN: assert (res_o[0] == c_i && flags_o[FL_C] == a_i[WIDTH-1]); // R11
        if (op_w == OP_AND || op_w == OP_OR || op_w == OP_XOR)
            AST_LOGIC_V_CLEAR: assert (!flags_o[FL_V] && !flag_we_o[FL_C]); // R6
        if (op_i > 5'd16)
            AST_UNUSED_PASS: assert (res_o == a_i && flag_we_o == '0); // R1
    end

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op;
    logic [7:0] a, b;
    logic       cin, zin;
    logic [7:0] res;
    logic [5:0] fl, we;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alu8_core #(.WIDTH(8)) dut_i (
        .op_i(op), .a_i(a), .b_i(b), .c_i(cin), .z_i(zin),
        .res_o(res), .flags_o(fl), .flag_we_o(we)
    );

    // Behavioural reference: result, flags {H,S,V,N,Z,C}, mask, requirement tag.
    function automatic void model(input int o, input int x, input int y,
                                  input int c, input int z,
                                  output int r, output int f, output int m,
                                  output string tag);
        int t, fc, fz, fn, fv, fh;
        fc = 0; fv = 0; fh = 0; m = 0; r = x;
        tag = "R1";
        case (o)
            0, 1: begin
                t = x + y + ((o == 1) ? c : 0);
                r = t & 255; fc = t >> 8;
                fh = ((x & 15) + (y & 15) + ((o == 1) ? c : 0)) >> 4;
                fv = (((x ^ r) & (y ^ r) & 128) != 0);
                m = 63; tag = "R3";
            end
            2, 3: begin
                t = x - y - ((o == 3) ? c : 0);
                r = t & 255; fc = (t < 0);
                fh = (((x & 15) - (y & 15) - ((o == 3) ? c : 0)) < 0);
                fv = (((x ^ y) & (x ^ r) & 128) != 0);
                m = 63; tag = (o == 3) ? "R4 R5" : "R4";
            end
            4: begin r = x & y; m = 30; tag = "R6"; end
            5: begin r = x | y; m = 30; tag = "R6"; end
            6: begin r = x ^ y; m = 30; tag = "R6"; end
            7: begin r = 255 - x; fc = 1; m = 31; tag = "R7"; end
            8: begin
                r = (256 - x) & 255; fc = (r != 0); fv = (r == 128);
                fh = ((x & 15) != 0); m = 63; tag = "R8";
            end
            9:  begin r = (x + 1) & 255; fv = (x == 127); m = 30; tag = "R9"; end
            10: begin r = (x + 255) & 255; fv = (x == 128); m = 30; tag = "R9"; end
            11: begin r = (x * 2) & 255; fc = x / 128; m = 31; tag = "R10 R13"; end
            12: begin r = x / 2; fc = x % 2; m = 31; tag = "R10 R13"; end
            13: begin r = ((x * 2) & 255) + c; fc = x / 128; m = 31; tag = "R11 R13"; end
            14: begin r = x / 2 + c * 128; fc = x % 2; m = 31; tag = "R11 R13"; end
            15: begin r = x / 2 + (x & 128); fc = x % 2; m = 31; tag = "R12 R13"; end
            16: begin r = ((x % 16) * 16) + x / 16; m = 0; tag = "R14"; end
            default: begin r = x; m = 0; tag = "R1"; end
        endcase
        fn = r / 128;
        fz = (r == 0);
        if (o == 3) fz = fz & z;
        if (o >= 11 && o <= 15) fv = fn ^ fc;
        f = fc | (fz << 1) | (fn << 2) | (fv << 3) | ((fn ^ fv) << 4) | (fh << 5);
    endfunction

    task automatic apply(input int o, input int x, input int y, input int c, input int z);
        int er, ef, em;
        string tag;
        @(posedge clk);
        op = 5'(o); a = 8'(x); b = 8'(y); cin = 1'(c); zin = 1'(z);
        @(negedge clk);
        model(o, x, y, c, z, er, ef, em, tag);
        checks++;
        if (int'(res) != er || int'(we) != em || (int'(fl) & em) != (ef & em)) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h c=%0d z=%0d: res=%02h fl=%02h we=%02h expected res=%02h fl=%02h we=%02h (R2 flag layout)",
                     tag, o, x, y, c, z, res, int'(fl) & em, we, er, ef & em, em);
        end
    endtask

    initial begin
        op = 5'd0; a = 8'h00; b = 8'h00; cin = 1'b0; zin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state inputs: ADD of zeros gives zero with Z set (R3, R5).
        apply(0, 0, 0, 0, 0);
        // R3 corners: signed overflow, carry with zero, half carry, ADC carry in.
        apply(0, 8'h7F, 8'h01, 0, 0);
        apply(0, 8'hFF, 8'h01, 0, 0);
        apply(0, 8'h0F, 8'h01, 0, 0);
        apply(1, 8'hFF, 8'h00, 1, 0);
        // R4 corners: overflow, borrow, half borrow, SBC borrow in.
        apply(2, 8'h80, 8'h01, 0, 0);
        apply(2, 8'h00, 8'h01, 0, 0);
        apply(2, 8'h10, 8'h01, 0, 0);
        apply(3, 8'h05, 8'h04, 1, 1);
        // R5: SBC zero result keeps or clears Z from z_i.
        apply(3, 8'h05, 8'h05, 0, 0);
        apply(3, 8'h05, 8'h04, 1, 0);
        // R8: NEG of 0x80 and 0x00.
        apply(8, 8'h80, 0, 0, 0);
        apply(8, 8'h00, 0, 1, 0);
        // R9: INC at 0x7F, DEC at 0x80, INC wrap to zero.
        apply(9, 8'h7F, 0, 1, 0);
        apply(10, 8'h80, 0, 1, 0);
        apply(9, 8'hFF, 0, 0, 0);
        // R11 / R12: rotates with carry set, ASR of negative value.
        apply(13, 8'h80, 0, 1, 0);
        apply(14, 8'h01, 0, 1, 0);
        apply(15, 8'h81, 0, 0, 0);
        // R14 / R1: swap and an unused code.
        apply(16, 8'hA5, 0, 1, 1);
        apply(31, 8'h3C, 8'hFF, 1, 1);
        // Sweep: every code, every left operand, random other inputs (R1..R14).
        for (int o = 0; o < 32; o++) begin
            for (int x = 0; x < 256; x++) begin
                apply(o, x, int'($urandom_range(0, 255)),
                      int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule